// File: doc/BRIEF.md
# Rotate-Through-Carry Read-Modify-Write Unit

This unit executes the rotate-left and rotate-right-through-carry instructions of a 16-bit accumulator processor whose memory/accumulator data width can be switched between 8 and 16 bits at run time. A sequencer hands it the opcode, the register file values, the carry flag and the two width flags together with a one-cycle start pulse. The unit fetches the instruction's operand bytes, forms the 24-bit effective address and reads the operand. It rotates the operand through the carry and writes the result back through a byte-wide memory port. When it finishes, it returns the new accumulator, program counter and flags, along with the number of CPU cycles the instruction costs.

The memory port is synchronous. A read issued with `mem_rd_o` in one cycle returns its byte on `mem_rdata_i` in the next cycle, which matches an inferred block RAM. Reads and writes never share a cycle. The accumulator form never touches memory. All results are held on registered outputs until the next completed instruction.

Top module: `rot_rmw_unit`

## Requirements
- R1: Only opcodes 0x26, 0x2A, 0x2E, 0x36, 0x3E (rotate left) and 0x66, 0x6A, 0x6E, 0x76, 0x7E (rotate right) are accepted. Any other opcode with `start_i` raises `illegal_o` for one cycle in the next cycle. In that case there is no `done_o` and no memory access, and all result outputs keep their values.
- R2: Rotate left places the incoming carry in bit 0 and shifts every other bit up by one. The outgoing carry is bit 7 when `mem8_i`=1 and bit 15 when `mem8_i`=0.
- R3: Rotate right places the incoming carry in the top bit of the active width (bit 7 or bit 15). The outgoing carry is bit 0.
- R4: `neg_o` is the top bit of the result at the active width. `zero_o` is set exactly when the result at the active width is zero.
- R5: The accumulator forms (0x2A, 0x6A) rotate `a_i` and perform no memory access. With `mem8_i`=1, bits 15:8 of `a_o` equal those of `a_i`. All memory forms return `a_o` equal to `a_i`.
- R6: Operand bytes are read from {`pbank_i`, `pc_i`} and, for the absolute forms, also from {`pbank_i`, `pc_i`+1}, low byte first. `pc_o` is `pc_i` plus 2 for absolute forms, plus 1 for direct-page forms, and plus 0 for accumulator forms.
- R7: Absolute (0x2E/0x6E) addresses {`dbank_i`, operand}. Absolute,X (0x3E/0x7E) addresses {`dbank_i`, (operand + `x_i`) mod 65536}.
- R8: Direct page (0x26/0x66) addresses the 24-bit sum `d_i` + operand byte. Direct page,X (0x36/0x76) also adds `x_i`, or only `x_i[7:0]` when `idx8_i`=1.
- R9: With `mem8_i`=1, exactly one byte is read and one byte is written at the effective address EA. With `mem8_i`=0, a 16-bit value is read and written little-endian at EA and EA+1, using two byte writes.
- R10: `cycles_o` for 8-bit/16-bit operation is: accumulator 2/2, absolute 6/7, absolute,X 7/8, direct page 5/6, direct page,X 6/7.
- R11: Both direct-page forms add one cycle to `cycles_o` when `d_i[7:0]` is non-zero.
- R12: `done_o` is a single-cycle pulse per accepted instruction. It rises only after the last write-back, and the result outputs are valid while it is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to execute `opcode_i` |
| opcode_i | input | 8 | Instruction opcode |
| a_i | input | 16 | Accumulator |
| x_i | input | 16 | X index register |
| d_i | input | 16 | Direct page register |
| pc_i | input | 16 | Address of the first operand byte |
| dbank_i | input | 8 | Data bank register |
| pbank_i | input | 8 | Program bank for operand fetch |
| carry_i | input | 1 | Carry flag before the instruction |
| mem8_i | input | 1 | 1 = 8-bit memory/accumulator width |
| idx8_i | input | 1 | 1 = 8-bit index width |
| mem_addr_o | output | 24 | Memory byte address |
| mem_rd_o | output | 1 | Read request, data returns the next cycle |
| mem_wr_o | output | 1 | Write strobe |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data |
| done_o | output | 1 | Instruction complete pulse |
| illegal_o | output | 1 | Unsupported opcode pulse |
| a_o | output | 16 | Updated accumulator |
| pc_o | output | 16 | Updated program counter |
| carry_o | output | 1 | Updated carry |
| neg_o | output | 1 | Updated negative flag |
| zero_o | output | 1 | Updated zero flag |
| cycles_o | output | 4 | Instruction cycle count |

## Verification
The bench runs every accepted opcode in both data widths, with both carry values and data patterns that have bit 0, bit 7 and bit 15 set and clear. A unit that takes the carry or the N flag from the wrong bit fails on these patterns. So does one that computes Z over all 16 bits in 8-bit mode, or that clobbers the accumulator high byte. The address configurations include an absolute,X sum that must wrap inside the bank, a direct page whose sum crosses into the next bank, an 8-bit index that must mask the high byte of X, and a direct page with a non-zero low byte. A design that carries into the bank, uses the full X, or omits the penalty would then access or report the wrong values. All 246 other opcodes are tried as well, to catch any decode that accepts a neighbour or disturbs the outputs.

// File: rtl/rot_pkg.sv
package rot_pkg;
  typedef enum logic [2:0] {AM_ACC, AM_ABS, AM_ABSX, AM_DP, AM_DPX} amode_t;
  typedef enum logic [3:0] {
    ST_IDLE, ST_F0, ST_F1, ST_F2, ST_EA, ST_R0, ST_R1, ST_R2,
    ST_ROT, ST_W0, ST_W1, ST_FIN
  } state_t;
endpackage

// File: rtl/rot_decode.sv
module rot_decode
  import rot_pkg::*;
(
  input  logic [7:0] opc,
  output logic       valid,
  output logic       right,
  output amode_t     mode
);
  always_comb begin
    valid = 1'b0;
    right = opc[6];
    mode  = AM_ACC;
    if (!opc[7] && opc[5]) begin
      case (opc[3:0])
        4'hA: begin valid = !opc[4]; mode = AM_ACC; end
        4'hE: begin valid = 1'b1; mode = opc[4] ? AM_ABSX : AM_ABS; end
        4'h6: begin valid = 1'b1; mode = opc[4] ? AM_DPX : AM_DP; end
        default: valid = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/rot_alu.sv
module rot_alu #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] val,
  input  logic              narrow,
  input  logic              right,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              cout,
  output logic              neg,
  output logic              zero
);
  localparam int HALF = DATA_W / 2;
  logic [HALF-1:0] lo, r_lo;

  always_comb begin
    lo   = val[HALF-1:0];
    r_lo = '0;
    if (narrow) begin
      if (right) begin
        r_lo = {cin, lo[HALF-1:1]};
        cout = lo[0];
      end else begin
        r_lo = {lo[HALF-2:0], cin};
        cout = lo[HALF-1];
      end
      res  = {{HALF{1'b0}}, r_lo};
      neg  = r_lo[HALF-1];
      zero = (r_lo == '0);
    end else begin
      if (right) begin
        res  = {cin, val[DATA_W-1:1]};
        cout = val[0];
      end else begin
        res  = {val[DATA_W-2:0], cin};
        cout = val[DATA_W-1];
      end
      neg  = res[DATA_W-1];
      zero = (res == '0);
    end
  end
endmodule

// File: rtl/rot_agen.sv
module rot_agen
  import rot_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 24
) (
  input  amode_t                   mode,
  input  logic [DATA_W-1:0]        oprnd,
  input  logic [DATA_W-1:0]        x,
  input  logic [DATA_W-1:0]        d,
  input  logic [ADDR_W-DATA_W-1:0] bank,
  input  logic                     idx8,
  output logic [ADDR_W-1:0]        ea
);
  localparam int HALF = DATA_W / 2;
  logic [DATA_W-1:0] xidx;
  logic [DATA_W-1:0] abs_sum;

  always_comb begin
    xidx    = idx8 ? {{HALF{1'b0}}, x[HALF-1:0]} : x;
    abs_sum = oprnd + x;
    case (mode)
      AM_ABS:  ea = {bank, oprnd};
      AM_ABSX: ea = {bank, abs_sum};
      AM_DP:   ea = ADDR_W'(d) + ADDR_W'(oprnd[HALF-1:0]);
      AM_DPX:  ea = ADDR_W'(d) + ADDR_W'(oprnd[HALF-1:0]) + ADDR_W'(xidx);
      default: ea = '0;
    endcase
  end
endmodule

// File: rtl/rot_cycles.sv
module rot_cycles
  import rot_pkg::*;
#(
  parameter int CYC_W = 4
) (
  input  amode_t           mode,
  input  logic             narrow,
  input  logic             dl_nz,
  output logic [CYC_W-1:0] cnt
);
  logic [CYC_W-1:0] wide_base;
  logic             is_dp;

  always_comb begin
    is_dp = (mode == AM_DP) || (mode == AM_DPX);
    case (mode)
      AM_ABS:  wide_base = CYC_W'(7);
      AM_ABSX: wide_base = CYC_W'(8);
      AM_DP:   wide_base = CYC_W'(6);
      AM_DPX:  wide_base = CYC_W'(7);
      default: wide_base = CYC_W'(2);
    endcase
    cnt = wide_base
        - CYC_W'(narrow && (mode != AM_ACC))
        + CYC_W'(is_dp && dl_nz);
  end
endmodule

// File: rtl/rot_rmw_unit.sv
module rot_rmw_unit
  import rot_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 24,
  parameter int CYC_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [7:0]        opcode_i,
  input  logic [15:0]       a_i,
  input  logic [15:0]       x_i,
  input  logic [15:0]       d_i,
  input  logic [15:0]       pc_i,
  input  logic [7:0]        dbank_i,
  input  logic [7:0]        pbank_i,
  input  logic              carry_i,
  input  logic              mem8_i,
  input  logic              idx8_i,
  output logic [23:0]       mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i,
  output logic              done_o,
  output logic              illegal_o,
  output logic [15:0]       a_o,
  output logic [15:0]       pc_o,
  output logic              carry_o,
  output logic              neg_o,
  output logic              zero_o,
  output logic [3:0]        cycles_o
);
  localparam int HALF   = DATA_W / 2;
  localparam int BANK_W = ADDR_W - DATA_W;

  state_t              state;
  amode_t              mode_q, dec_mode;
  logic                dec_valid, dec_right;
  logic                right_q, m_q, xf_q, c_q;
  logic [DATA_W-1:0]   a_q, x_q, d_q, pc_q, dat_q, res_q;
  logic [BANK_W-1:0]   db_q, pb_q;
  logic [HALF-1:0]     op_lo, op_hi;
  logic [ADDR_W-1:0]   ea_q, agen_ea;
  logic                rc_q, rn_q, rz_q;
  logic [DATA_W-1:0]   alu_res;
  logic                alu_c, alu_n, alu_z;
  logic [CYC_W-1:0]    cyc_cnt;
  logic                is_abs, is_acc;
  logic [DATA_W-1:0]   pc_len;

  rot_decode u_dec (.opc(opcode_i), .valid(dec_valid), .right(dec_right), .mode(dec_mode));

  rot_alu #(.DATA_W(DATA_W)) u_alu (
    .val(dat_q), .narrow(m_q), .right(right_q), .cin(c_q),
    .res(alu_res), .cout(alu_c), .neg(alu_n), .zero(alu_z)
  );

  rot_agen #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_agen (
    .mode(mode_q), .oprnd({op_hi, op_lo}), .x(x_q), .d(d_q),
    .bank(db_q), .idx8(xf_q), .ea(agen_ea)
  );

  rot_cycles #(.CYC_W(CYC_W)) u_cyc (
    .mode(mode_q), .narrow(m_q), .dl_nz(d_q[HALF-1:0] != '0), .cnt(cyc_cnt)
  );

  assign is_abs = (mode_q == AM_ABS) || (mode_q == AM_ABSX);
  assign is_acc = (mode_q == AM_ACC);
  assign pc_len = is_abs ? DATA_W'(2) : (is_acc ? DATA_W'(0) : DATA_W'(1));

  // Memory port, driven from registered state
  always_comb begin
    mem_addr_o  = '0;
    mem_rd_o    = 1'b0;
    mem_wr_o    = 1'b0;
    mem_wdata_o = '0;
    case (state)
      ST_F0: begin mem_rd_o = 1'b1; mem_addr_o = {pb_q, pc_q}; end
      ST_F1: if (is_abs) begin
        mem_rd_o = 1'b1; mem_addr_o = {pb_q, pc_q + DATA_W'(1)};
      end
      ST_R0: begin mem_rd_o = 1'b1; mem_addr_o = ea_q; end
      ST_R1: if (!m_q) begin
        mem_rd_o = 1'b1; mem_addr_o = ea_q + ADDR_W'(1);
      end
      ST_W0: begin mem_wr_o = 1'b1; mem_addr_o = ea_q; mem_wdata_o = res_q[HALF-1:0]; end
      ST_W1: begin mem_wr_o = 1'b1; mem_addr_o = ea_q + ADDR_W'(1); mem_wdata_o = res_q[DATA_W-1:HALF]; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      done_o <= 1'b0; illegal_o <= 1'b0;
      a_o <= '0; pc_o <= '0; carry_o <= 1'b0; neg_o <= 1'b0; zero_o <= 1'b0;
      cycles_o <= '0;
      mode_q <= AM_ACC; right_q <= 1'b0; m_q <= 1'b0; xf_q <= 1'b0; c_q <= 1'b0;
      a_q <= '0; x_q <= '0; d_q <= '0; pc_q <= '0; dat_q <= '0; res_q <= '0;
      db_q <= '0; pb_q <= '0; op_lo <= '0; op_hi <= '0; ea_q <= '0;
      rc_q <= 1'b0; rn_q <= 1'b0; rz_q <= 1'b0;
    end else begin
      done_o    <= 1'b0;
      illegal_o <= 1'b0;
      case (state)
        ST_IDLE: if (start_i) begin
          if (!dec_valid) begin
            illegal_o <= 1'b1;
          end else begin
            mode_q <= dec_mode; right_q <= dec_right;
            m_q <= mem8_i; xf_q <= idx8_i; c_q <= carry_i;
            a_q <= a_i; x_q <= x_i; d_q <= d_i; pc_q <= pc_i;
            db_q <= dbank_i; pb_q <= pbank_i;
            op_lo <= '0; op_hi <= '0;
            dat_q <= a_i;
            state <= (dec_mode == AM_ACC) ? ST_ROT : ST_F0;
          end
        end
        ST_F0: state <= ST_F1;
        ST_F1: begin
          op_lo <= mem_rdata_i;
          state <= is_abs ? ST_F2 : ST_EA;
        end
        ST_F2: begin op_hi <= mem_rdata_i; state <= ST_EA; end
        ST_EA: begin ea_q <= agen_ea; state <= ST_R0; end
        ST_R0: state <= ST_R1;
        ST_R1: begin
          dat_q[HALF-1:0] <= mem_rdata_i;
          state <= m_q ? ST_ROT : ST_R2;
        end
        ST_R2: begin dat_q[DATA_W-1:HALF] <= mem_rdata_i; state <= ST_ROT; end
        ST_ROT: begin
          res_q <= alu_res; rc_q <= alu_c; rn_q <= alu_n; rz_q <= alu_z;
          state <= is_acc ? ST_FIN : ST_W0;
        end
        ST_W0: state <= m_q ? ST_FIN : ST_W1;
        ST_W1: state <= ST_FIN;
        ST_FIN: begin
          done_o   <= 1'b1;
          carry_o  <= rc_q; neg_o <= rn_q; zero_o <= rz_q;
          a_o      <= !is_acc ? a_q :
                      (m_q ? {a_q[DATA_W-1:HALF], res_q[HALF-1:0]} : res_q);
          pc_o     <= pc_q + pc_len;
          cycles_o <= cyc_cnt;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R12: completion is a single pulse
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R1: a rejected opcode never completes in the same cycle
  a_r1_illegal_no_done: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> !done_o);
  // R1: a rejected opcode starts no memory traffic
  a_r1_illegal_quiet: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> (state == ST_IDLE) && !mem_rd_o && !mem_wr_o);
  // R9: the byte port never reads and writes together
  a_r9_port_excl: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_o && mem_wr_o));
  // R5: accumulator form stays off the memory port
  a_r5_acc_nomem: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && is_acc) |-> !mem_rd_o && !mem_wr_o);
  // R5: 8-bit accumulator rotate keeps the high byte
  a_r5_hi_keep: assert property (@(posedge clk) disable iff (rst)
    (done_o && is_acc && m_q) |-> a_o[DATA_W-1:HALF] == a_q[DATA_W-1:HALF]);
  // R10: reported cycle count lies within the table plus penalty
  a_r10_cyc_range: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (cycles_o >= 4'd2) && (cycles_o <= 4'd8));
  // R9: a write of the high byte always follows the low byte
  a_r9_hi_after_lo: assert property (@(posedge clk) disable iff (rst)
    (state == ST_W1) |-> $past(state == ST_W0));
endmodule

// File: tb/sim_rot_rmw_unit.sv
module sim_rot_rmw_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        start_i = 1'b0;
  logic [7:0]  opcode_i = '0;
  logic [15:0] a_i = '0, x_i = '0, d_i = '0, pc_i = '0;
  logic [7:0]  dbank_i = '0, pbank_i = '0;
  logic        carry_i = 1'b0, mem8_i = 1'b0, idx8_i = 1'b0;
  logic [23:0] mem_addr_o;
  logic        mem_rd_o, mem_wr_o;
  logic [7:0]  mem_wdata_o;
  logic [7:0]  mem_rdata_i = '0;
  logic        done_o, illegal_o;
  logic [15:0] a_o, pc_o;
  logic        carry_o, neg_o, zero_o;
  logic [3:0]  cycles_o;

  rot_rmw_unit u0 (.*);

  int errors = 0, checks = 0;
  int rd_cnt = 0, wr_cnt = 0;
  logic [7:0] mem [logic [23:0]];

  function automatic logic [7:0] rd_mem(logic [23:0] a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  always @(posedge clk) begin
    if (mem_rd_o) begin
      mem_rdata_i <= rd_mem(mem_addr_o);
      rd_cnt = rd_cnt + 1;
    end
    if (mem_wr_o) begin
      mem[mem_addr_o] = mem_wdata_o;
      wr_cnt = wr_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int bmode(logic [7:0] op);
    case (op)
      8'h2A, 8'h6A: return 0;
      8'h2E, 8'h6E: return 1;
      8'h3E, 8'h7E: return 2;
      8'h26, 8'h66: return 3;
      8'h36, 8'h76: return 4;
      default:      return -1;
    endcase
  endfunction

  task automatic run(input logic [7:0] op, input bit m, input bit xf, input bit c,
                     input logic [15:0] a, input logic [15:0] x, input logic [15:0] d,
                     input logic [7:0] db, input logic [15:0] opnd, input logic [15:0] data);
    int md, w, len, cyc, waitc;
    logic [15:0] pc, v, mask, r, xi, sum16;
    logic [23:0] ea;
    logic [7:0] pb;
    bit cout, right;
    md = bmode(op);
    right = op[6];
    pc = 16'h3400; pb = 8'h12;
    mem.delete();
    mem[{pb, pc}] = opnd[7:0];
    mem[{pb, pc + 16'd1}] = opnd[15:8];
    xi = xf ? {8'h00, x[7:0]} : x;
    sum16 = opnd + x;
    case (md)
      1: ea = {db, opnd};
      2: ea = {db, sum16};
      3: ea = 24'(d) + 24'(opnd[7:0]);
      4: ea = 24'(d) + 24'(opnd[7:0]) + 24'(xi);
      default: ea = '0;
    endcase
    if (md != 0) begin
      mem[ea] = data[7:0];
      if (!m) mem[ea + 24'd1] = data[15:8];
    end
    w = m ? 8 : 16;
    mask = m ? 16'h00FF : 16'hFFFF;
    v = ((md == 0) ? a : data) & mask;
    if (right) begin
      r = (v >> 1) | (16'(c) << (w - 1));
      cout = v[0];
    end else begin
      r = ((v << 1) | 16'(c)) & mask;
      cout = v[w-1];
    end
    len = (md == 1 || md == 2) ? 2 : (md == 0 ? 0 : 1);
    case (md)
      1: cyc = 6; 2: cyc = 7; 3: cyc = 5; 4: cyc = 6; default: cyc = 2;
    endcase
    if (md != 0 && !m) cyc++;
    if ((md == 3 || md == 4) && d[7:0] != 8'h00) cyc++;

    @(negedge clk);
    opcode_i = op; mem8_i = m; idx8_i = xf; carry_i = c;
    a_i = a; x_i = x; d_i = d; dbank_i = db; pbank_i = pb; pc_i = pc;
    rd_cnt = 0; wr_cnt = 0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    waitc = 0;
    while (!done_o && waitc < 40) begin @(negedge clk); waitc++; end
    chk(done_o == 1'b1, "R12", "done seen", int'(done_o), 1);

    if (md == 0) begin
      chk(a_o == (m ? {a[15:8], r[7:0]} : r), "R5", "acc result", a_o, m ? {a[15:8], r[7:0]} : r);
      chk(rd_cnt == 0 && wr_cnt == 0, "R5", "acc mem access", rd_cnt + wr_cnt, 0);
    end else begin
      chk(a_o == a, "R5", "A unchanged by memory form", a_o, a);
      chk(rd_mem(ea) == r[7:0], right ? "R3" : "R2", "low byte at EA", rd_mem(ea), r[7:0]);
      if (!m)
        chk(rd_mem(ea + 24'd1) == r[15:8], "R9", "high byte at EA+1", rd_mem(ea + 24'd1), r[15:8]);
      chk(wr_cnt == (m ? 1 : 2), "R9", "write count", wr_cnt, m ? 1 : 2);
      chk(rd_cnt == len + (m ? 1 : 2), (md <= 2) ? "R7" : "R8", "read count", rd_cnt, len + (m ? 1 : 2));
    end
    chk(carry_o == cout, right ? "R3" : "R2", "carry", carry_o, cout);
    chk(neg_o == r[w-1], "R4", "negative", neg_o, r[w-1]);
    chk(zero_o == (r == 16'h0), "R4", "zero", zero_o, r == 16'h0);
    chk(pc_o == pc + 16'(len), "R6", "pc", pc_o, pc + 16'(len));
    chk(cycles_o == 4'(cyc), (md >= 3) ? "R11" : "R10", "cycles", cycles_o, cyc);
    @(negedge clk);
    chk(done_o == 1'b0, "R12", "done width", done_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog timeout");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0]  ops [10] = '{8'h2A, 8'h2E, 8'h3E, 8'h26, 8'h36, 8'h6A, 8'h6E, 8'h7E, 8'h66, 8'h76};
    logic [15:0] pats [6] = '{16'h0000, 16'h8001, 16'h4000, 16'h0080, 16'hFFFF, 16'h7F01};
    logic [15:0] ds [3] = '{16'h0000, 16'h1203, 16'hFFF0};
    logic [15:0] xs [2] = '{16'h0005, 16'hFF10};
    logic [15:0] prev_a;
    logic [3:0]  prev_c;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(done_o == 0 && illegal_o == 0, "R12", "reset pulses", {done_o, illegal_o}, 0);
    chk(a_o == 0 && cycles_o == 0 && pc_o == 0, "R12", "reset outputs", a_o, 0);
    chk(!mem_rd_o && !mem_wr_o, "R9", "reset port idle", {mem_rd_o, mem_wr_o}, 0);

    for (int oi = 0; oi < 10; oi++)
      for (int m = 0; m < 2; m++)
        for (int c = 0; c < 2; c++)
          for (int p = 0; p < 6; p++)
            run(ops[oi], m[0], p[0], c[0], 16'hA5C3 ^ pats[p], xs[p % 2], ds[p % 3],
                8'h05, (p % 2 == 1) ? 16'hFFF8 : 16'h00F0, pats[p]);

    // R8: direct page sum crossing into the next bank, full X
    run(8'h36, 1'b0, 1'b0, 1'b1, 16'h1111, 16'h0200, 16'hFF00, 8'h05, 16'h0080, 16'h8001);
    // R11: penalty applies with only low byte of D set
    run(8'h66, 1'b1, 1'b0, 1'b0, 16'h2222, 16'h0000, 16'h0001, 8'h05, 16'h0010, 16'h0002);

    // R1: every other opcode is refused with no effect
    prev_a = a_o; prev_c = cycles_o;
    for (int op = 0; op < 256; op++) begin
      if (bmode(8'(op)) < 0) begin
        @(negedge clk);
        opcode_i = 8'(op); a_i = 16'hDEAD; rd_cnt = 0; wr_cnt = 0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(illegal_o && !done_o && rd_cnt == 0 && wr_cnt == 0 &&
            a_o == prev_a && cycles_o == prev_c,
            "R1", $sformatf("reject op %0h", op), {illegal_o, done_o}, 2);
      end
    end
    @(negedge clk);
    chk(!illegal_o, "R1", "illegal pulse width", illegal_o, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule